// File: doc/BRIEF.md
# Runtime Accuracy-Configurable Ripple Adder

This block is a combinational two-operand adder. Its carry chain is cut into equal-width ripple segments. A single mode level picks, at run time, between exact addition and a faster approximate addition. In exact mode every segment boundary forwards the real carry, and the result is the true sum. In approximate mode each boundary forwards a predicted carry instead. The prediction is the generate term (a AND b) of the segment's top bit. This shortens the longest carry path to roughly one segment plus one bit.

The lowest bit of every upper segment still forms its sum bit from the true carry leaving the segment below. Only the carry that ripples onward from that bit uses the selected value. As a result, the lowest segment plus one bit are exact in both modes. Errors appear only higher up, when a propagate run crosses a boundary with no generate at the boundary bit. The block is meant for error-tolerant datapaths such as shift-and-add filter trees, where a mode pin trades accuracy for delay and power.

Top module: `acc_config_adder`

## Requirements
- R1: With `approx_i` = 0 (exact mode), {`cout_o`, `sum_o`} equals `a_i` + `b_i` + `cin_i` for every input.
- R2: In both modes, the low SEG_W+1 bits of `sum_o` (bits 0..4 by default) equal the same bits of the exact sum.
- R3: In approximate mode, the lowest bit of each upper segment (bits 4 and 8 by default) is a XOR b XOR the true carry out of the top bit of the segment below.
- R4: In approximate mode, the carry fed up the chain from a boundary is a AND b of the boundary's top bit (bits 3 and 7 by default), whatever carry arrived there; e.g. 0x01F + 0x001 gives 0x000.
- R5: Inside a segment, carries ripple bit to bit exactly, starting from the carry the segment's chain receives.
- R6: `cout_o` is the carry out of the top bit of the top segment, computed from that segment's chain carry; e.g. approximate 0xFFF + 0x001 gives `cout_o` = 0 and `sum_o` = 0xFE0.
- R7: The block holds no state: `sum_o` and `cout_o` follow any change of operands or mode with no clock edge, and all-zero inputs give an all-zero result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH (12) | First operand |
| b_i | input | WIDTH (12) | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| approx_i | input | 1 | Mode level: 0 exact, 1 approximate |
| sum_o | output | WIDTH (12) | Sum bits |
| cout_o | output | 1 | Carry out of the top bit |

## Verification
Because the block has no state, a wrong boundary selection or a misrouted carry shows at the ports as soon as the inputs settle. It shows on the very vector that excites it. The bench therefore checks each vector in the same cycle it is applied. Exact-mode faults surface as a mismatch against the integer sum. A fault that feeds the predicted carry into a sum bit, or the true carry into the chain, surfaces only in approximate mode, and only on vectors with a propagate run across a boundary. For that reason the bench steers directed vectors at bits 3/4 and 7/8, in addition to random operands.

// File: rtl/acc_adder_pkg.sv
package acc_adder_pkg;

    localparam int unsigned ADD_W = 12;
    localparam int unsigned SEG_W = 4;

    typedef enum logic {
        MODE_EXACT  = 1'b0,
        MODE_APPROX = 1'b1
    } add_mode_e;

    typedef struct packed {
        logic prop;
        logic gen;
    } pg_t;

    function automatic pg_t pg_of(input logic a, input logic b);
        pg_t r;
        r.prop = a ^ b;
        r.gen  = a & b;
        return r;
    endfunction

endpackage

// File: rtl/acc_bit_cell.sv
module acc_bit_cell
    import acc_adder_pkg::*;
(
    input  logic a,
    input  logic b,
    input  logic c_sum,
    input  logic c_chain,
    output logic s,
    output logic c_out,
    output logic gen
);
    pg_t pg;

    always_comb begin
        pg    = pg_of(a, b);
        s     = pg.prop ^ c_sum;
        c_out = pg.gen | (pg.prop & c_chain);
        gen   = pg.gen;
    end
endmodule

// File: rtl/acc_segment.sv
module acc_segment #(
    parameter int unsigned SEG_W = 4
) (
    input  logic [SEG_W-1:0] a,
    input  logic [SEG_W-1:0] b,
    input  logic             cin_sum,
    input  logic             cin_chain,
    output logic [SEG_W-1:0] sum,
    output logic             cout,
    output logic             gen_top
);
    logic [SEG_W-1:0] carry;
    logic [SEG_W-1:0] gen;

    for (genvar j = 0; j < SEG_W; j++) begin : g_bit
        logic cs;
        logic cc;
        if (j == 0) begin : g_first
            assign cs = cin_sum;
            assign cc = cin_chain;
        end else begin : g_rest
            assign cs = carry[j-1];
            assign cc = carry[j-1];
        end
        acc_bit_cell u_cell (
            .a      (a[j]),
            .b      (b[j]),
            .c_sum  (cs),
            .c_chain(cc),
            .s      (sum[j]),
            .c_out  (carry[j]),
            .gen    (gen[j])
        );
    end

    assign cout    = carry[SEG_W-1];
    assign gen_top = gen[SEG_W-1];

    // R5: when both entry carries agree the segment is a plain ripple adder
    always_comb begin
        if (cin_sum == cin_chain) begin
            p_seg_ripple_r5: assert ({cout, sum} ==
                ({1'b0, a} + {1'b0, b} + {{SEG_W{1'b0}}, cin_sum}))
                else $error("segment ripple mismatch");
        end
    end
endmodule

// File: rtl/acc_boundary_mux.sv
module acc_boundary_mux
    import acc_adder_pkg::*;
(
    input  add_mode_e mode,
    input  logic      carry_true,
    input  logic      gen_top,
    output logic      carry_sel
);
    always_comb begin
        unique case (mode)
            MODE_APPROX: carry_sel = gen_top;
            default:     carry_sel = carry_true;
        endcase
    end

    // R4: a generate always implies a real carry, so the forwarded carry
    // can only under-estimate the true one
    always_comb begin
        p_pred_le_true_r4: assert (!carry_sel || carry_true)
            else $error("selected carry exceeds true carry");
    end
endmodule

// File: rtl/acc_config_adder.sv
module acc_config_adder
    import acc_adder_pkg::*;
#(
    parameter int unsigned WIDTH = ADD_W,
    parameter int unsigned SEG_W = acc_adder_pkg::SEG_W
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    input  logic             approx_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);
    localparam int unsigned NSEG  = WIDTH / SEG_W;
    localparam int unsigned LOW_W = (NSEG > 1) ? SEG_W + 1 : WIDTH;

    add_mode_e mode;
    assign mode = add_mode_e'(approx_i);

    logic [NSEG-1:0] seg_cout;
    logic [NSEG-1:0] seg_gen;
    logic [NSEG-1:0] seg_sel;

    for (genvar k = 0; k < NSEG; k++) begin : g_seg
        logic c_sum_in;
        logic c_chain_in;
        if (k == 0) begin : g_base
            assign c_sum_in   = cin_i;
            assign c_chain_in = cin_i;
        end else begin : g_upper
            assign c_sum_in   = seg_cout[k-1];
            assign c_chain_in = seg_sel[k-1];
        end

        acc_segment #(.SEG_W(SEG_W)) u_seg (
            .a        (a_i[k*SEG_W +: SEG_W]),
            .b        (b_i[k*SEG_W +: SEG_W]),
            .cin_sum  (c_sum_in),
            .cin_chain(c_chain_in),
            .sum      (sum_o[k*SEG_W +: SEG_W]),
            .cout     (seg_cout[k]),
            .gen_top  (seg_gen[k])
        );

        acc_boundary_mux u_mux (
            .mode      (mode),
            .carry_true(seg_cout[k]),
            .gen_top   (seg_gen[k]),
            .carry_sel (seg_sel[k])
        );
    end

    assign cout_o = seg_cout[NSEG-1];

    logic [WIDTH:0] exact_sum;
    assign exact_sum = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};

    always_comb begin
        if (mode == MODE_EXACT) begin
            p_exact_sum_r1: assert ({cout_o, sum_o} == exact_sum)
                else $error("exact mode sum wrong");
        end
        p_low_exact_r2: assert (sum_o[LOW_W-1:0] == exact_sum[LOW_W-1:0])
            else $error("low bits differ from exact sum");
    end
endmodule

// File: tb/tb_acc_config_adder.sv
module tb_acc_config_adder;
    localparam int W  = 12;
    localparam int SW = 4;
    localparam int NS = W / SW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [W-1:0] a, b, sum;
    logic cin, approx, cout;

    int n_tests = 0;
    int n_fail  = 0;
    int approx_miss = 0;
    bit done = 1'b0;

    acc_config_adder dut (
        .a_i(a), .b_i(b), .cin_i(cin), .approx_i(approx),
        .sum_o(sum), .cout_o(cout)
    );

    function automatic logic [W:0] model(input logic [W-1:0] x, input logic [W-1:0] y,
                                         input logic ci, input logic ap);
        logic [W:0] r = '0;
        int cs = ci;
        int cc = ci;
        for (int k = 0; k < NS; k++) begin
            int sa = (int'(x) >> (k*SW)) & 15;
            int sb = (int'(y) >> (k*SW)) & 15;
            int t  = sa + sb + cc;
            int lo = (sa ^ sb ^ cs) & 1;
            int bits = (t & 14) | lo;
            int ctrue = (t >> SW) & 1;
            int pred  = (sa >> (SW-1)) & (sb >> (SW-1)) & 1;
            r = r | ((W+1)'(bits) << (k*SW));
            cs = ctrue;
            cc = ap ? pred : ctrue;
        end
        r[W] = cs[0];
        return r;
    endfunction

    task automatic check(input string req, input logic [W:0] got, input logic [W:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
        end
    endtask

    task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y,
                         input logic ci, input logic ap);
        @(posedge clk);
        a = x; b = y; cin = ci; approx = ap;
        @(negedge clk);
    endtask

    initial begin
        a = '0; b = '0; cin = 1'b0; approx = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R7 zero inputs", {cout, sum}, 13'h0000);

        apply(12'h01F, 12'h001, 1'b0, 1'b0);
        check("R1 exact 0x01F+1", {cout, sum}, 13'h0020);
        apply(12'h01F, 12'h001, 1'b0, 1'b1);
        check("R4 approx lost carry", {cout, sum}, 13'h0000);
        apply(12'h018, 12'h008, 1'b0, 1'b1);
        check("R4 approx predicted carry", {cout, sum}, 13'h0020);
        apply(12'h00F, 12'h001, 1'b0, 1'b1);
        check("R3 boundary sum bit", {cout, sum}, 13'h0010);
        apply(12'h0F0, 12'h010, 1'b0, 1'b1);
        check("R3 upper boundary sum bit", {cout, sum}, 13'h0100);
        apply(12'h070, 12'h010, 1'b0, 1'b1);
        check("R5 ripple inside segment", {cout, sum}, 13'h0080);
        apply(12'hFFF, 12'h001, 1'b0, 1'b1);
        check("R6 approx carry out", {cout, sum}, 13'h0FE0);
        apply(12'hFFF, 12'h001, 1'b0, 1'b0);
        check("R6 exact carry out", {cout, sum}, 13'h1000);
        apply(12'h800, 12'h800, 1'b0, 1'b1);
        check("R6 top generate", {cout, sum}, 13'h1000);
        apply(12'hFFF, 12'hFFF, 1'b1, 1'b0);
        check("R1 all ones with carry in", {cout, sum}, 13'h1FFF);

        // R7: mode flip with no clock edge
        @(posedge clk);
        a = 12'h01F; b = 12'h001; cin = 1'b0; approx = 1'b1;
        #0.5;
        check("R7 approx level", {cout, sum}, 13'h0000);
        approx = 1'b0;
        #0.5;
        check("R7 exact level no edge", {cout, sum}, 13'h0020);

        for (int i = 0; i < 3000; i++) begin
            logic [W-1:0] x = W'($urandom);
            logic [W-1:0] y = W'($urandom);
            logic ci = 1'($urandom);
            logic [W:0] ex = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
            apply(x, y, ci, 1'b0);
            check("R1 random exact", {cout, sum}, ex);
            apply(x, y, ci, 1'b1);
            check("R3 R4 R5 random approx", {cout, sum}, model(x, y, ci, 1'b1));
            check("R2 low bits exact", {8'h00, sum[SW:0]}, {8'h00, ex[SW:0]});
            if ({cout, sum} !== ex) approx_miss++;
        end
        $display("[TB] approximate results differing from exact: %0d of 3000", approx_miss);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule